// File: doc/BRIEF.md
# Product-Term-Sharing Logic Block

This block is a small configurable logic cell for a programmable fabric. Eighteen input signals, sixteen from the fabric's routing and two dedicated lines, feed an AND array that forms twenty product terms. The terms are pooled into four OR gates of unequal size. Each of the four outputs takes any OR gate as its primary operand, and optionally a second one, through a two-bit select. A small XOR-based update stage then lets each output register behave as a D, toggle or JK flip-flop, or as a D flip-flop loaded with the XOR of two OR gates.

Each output register has its own clock-enable choice among three shared enables, which stand in for three global clocks inside a single clock domain. An output can also skip its register and present its combinational value directly. All AND-array literals and per-output settings sit in configuration words written through a simple address/data port.

Top module: `pt_share_block`

## Requirements
- R1: The input vector is `{in_ded, in_route}`, so routed input j has index j (0..15) and dedicated input j has index 16+j. Configuration word k (address k, 0..19) programs product term k: data bit 2j enables the true literal of input j, and bit 2j+1 enables its complement. The term is the AND of all enabled literals.
- R2: A product term with no enabled literal is 0, so it adds nothing to its OR gate.
- R3: OR gate 0 sums terms 0..3, gate 1 sums terms 4..7, gate 2 sums terms 8..12 and gate 3 sums terms 13..19.
- R4: Address 20+i programs output i. Data bits [1:0] give the primary gate, [3:2] the auxiliary gate, [5:4] the mode, bit 6 the bypass, and [8:7] the clock-enable select. Any gate may feed any output, and several outputs may use the same gate.
- R5: In mode 0 (D), an enabled register loads the primary gate value.
- R6: In mode 1 (T), an enabled register inverts when the primary gate is 1 and holds otherwise.
- R7: In mode 2 (JK), the primary gate is J and the auxiliary gate is K. On an enabled edge: J=0,K=0 holds; J=1,K=0 sets; J=0,K=1 clears; J=1,K=1 inverts.
- R8: In mode 3 (XOR), an enabled register loads primary XOR auxiliary.
- R9: With bypass set, the output shows the combinational value in the same cycle: primary XOR auxiliary in mode 3, and the primary gate in every other mode. With bypass clear, the output shows the register.
- R10: A clock-enable select of 0, 1 or 2 picks `clk_en[0]`, `clk_en[1]` or `clk_en[2]`. A select of 3 never enables the register. A register whose selected enable is low holds its value.
- R11: A synchronous reset clears all four registers to 0 and leaves the configuration unchanged.
- R12: A configuration write applies from the following edge. A write to addresses 24..31 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| in_route | input | 16 | Inputs from the routing fabric |
| in_ded | input | 2 | Dedicated inputs |
| clk_en | input | 3 | Three shared clock enables |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_data | input | 36 | Configuration word data |
| y_out | output | 4 | Block outputs |

## Verification
On every cycle, the embedded properties check the register update rules: the D load, the T inversion, JK set and clear, hold while the selected enable is low, reset clearing, and a zero term whenever no literal is enabled. Some behaviours can only be shown by the bench's scenarios. These are the mapping of literals to input indices, the fixed grouping of terms into gates, the sharing of one gate by two outputs, the combinational bypass path, the never-enable select, and the configuration surviving reset or ignoring unused addresses. For these, the bench writes concrete configurations and compares the outputs with hand-derived values.

// File: rtl/ptsb_pkg.sv
package ptsb_pkg;

  localparam int NUM_GRP = 4;
  localparam int GRP_SIZE [NUM_GRP] = '{4, 4, 5, 7};

  typedef enum logic [1:0] {
    MODE_D   = 2'd0,
    MODE_T   = 2'd1,
    MODE_JK  = 2'd2,
    MODE_XOR = 2'd3
  } upd_mode_e;

  typedef struct packed {
    logic [1:0] clk_sel;
    logic       bypass;
    upd_mode_e  mode;
    logic [1:0] aux_sel;
    logic [1:0] pri_sel;
  } out_cfg_t;

  function automatic int grp_lo(input int g);
    int acc;
    acc = 0;
    for (int i = 0; i < g; i++) acc += GRP_SIZE[i];
    return acc;
  endfunction

endpackage

// File: rtl/ptsb_and_array.sv
module ptsb_and_array #(
  parameter int NUM_IN = 18,
  parameter int NUM_PT = 20,
  localparam int LW = 2 * NUM_IN
) (
  input  logic [NUM_IN-1:0] in_vec,
  input  logic [LW-1:0]     lit_cfg [NUM_PT],
  output logic [NUM_PT-1:0] pt
);

  logic [LW-1:0] lit_val;

  always_comb begin
    for (int j = 0; j < NUM_IN; j++) begin
      lit_val[2*j]   = in_vec[j];
      lit_val[2*j+1] = ~in_vec[j];
    end
  end

  for (genvar k = 0; k < NUM_PT; k++) begin : g_term
    assign pt[k] = (lit_cfg[k] != '0) && ((lit_val & lit_cfg[k]) == lit_cfg[k]);

    // R2: an unprogrammed term never contributes
    always_comb begin
      if (lit_cfg[k] == '0) a_r2_empty_term_low: assert (pt[k] == 1'b0);
    end
  end

endmodule

// File: rtl/ptsb_share_array.sv
module ptsb_share_array
  import ptsb_pkg::*;
#(
  parameter int NUM_PT = 20
) (
  input  logic [NUM_PT-1:0]  pt,
  output logic [NUM_GRP-1:0] grp
);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_or
    localparam int LO = grp_lo(g);
    localparam int SZ = GRP_SIZE[g];
    assign grp[g] = |pt[LO +: SZ];

    // R3: a gate whose terms are all low stays low
    always_comb begin
      if (pt[LO +: SZ] == '0) a_r3_gate_low: assert (grp[g] == 1'b0);
    end
  end

endmodule

// File: rtl/ptsb_out_cell.sv
module ptsb_out_cell
  import ptsb_pkg::*;
#(
  parameter int NUM_CE = 3,
  localparam int NSEL = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CE-1:0]  ce,
  input  logic [NUM_GRP-1:0] grp,
  input  out_cfg_t           cfg,
  output logic               y
);

  logic [NSEL-1:0] ce_ext;
  logic s, t, en, comb_val, d, q;

  assign ce_ext   = NSEL'(ce);
  assign en       = ce_ext[cfg.clk_sel];
  assign s        = grp[cfg.pri_sel];
  assign t        = grp[cfg.aux_sel];
  assign comb_val = (cfg.mode == MODE_XOR) ? (s ^ t) : s;

  always_comb begin
    case (cfg.mode)
      MODE_D:   d = s;
      MODE_T:   d = q ^ s;
      MODE_JK:  d = (s & ~q) | (~t & q);
      MODE_XOR: d = s ^ t;
      default:  d = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (en) q <= d;
  end

  assign y = cfg.bypass ? comb_val : q;

  a_r11_reset_clears: assert property (@(posedge clk) rst |=> (q == 1'b0));

  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  a_r5_d_load: assert property (@(posedge clk) disable iff (rst)
    (en && cfg.mode == MODE_D) |=> (q == $past(s)));

  a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
    (en && cfg.mode == MODE_T && s) |=> (q != $past(q)));

  a_r7_jk_set: assert property (@(posedge clk) disable iff (rst)
    (en && cfg.mode == MODE_JK && s && !t) |=> q);

  a_r7_jk_clear: assert property (@(posedge clk) disable iff (rst)
    (en && cfg.mode == MODE_JK && !s && t) |=> !q);

endmodule

// File: rtl/pt_share_block.sv
module pt_share_block
  import ptsb_pkg::*;
#(
  parameter int NUM_ROUTE = 16,
  parameter int NUM_DED   = 2,
  parameter int NUM_PT    = 20,
  parameter int NUM_CE    = 3,
  localparam int NUM_IN  = NUM_ROUTE + NUM_DED,
  localparam int NUM_OUT = NUM_GRP,
  localparam int CFG_DW  = 2 * NUM_IN,
  localparam int CFG_AW  = $clog2(NUM_PT + NUM_OUT),
  localparam int OCW     = $bits(out_cfg_t)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_ROUTE-1:0] in_route,
  input  logic [NUM_DED-1:0]   in_ded,
  input  logic [NUM_CE-1:0]    clk_en,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_data,
  output logic [NUM_OUT-1:0]   y_out
);

  logic [CFG_DW-1:0]  term_cfg [NUM_PT];
  out_cfg_t           out_cfg  [NUM_OUT];
  logic [NUM_IN-1:0]  in_vec;
  logic [NUM_PT-1:0]  pt;
  logic [NUM_GRP-1:0] grp;

  assign in_vec = {in_ded, in_route};

  for (genvar k = 0; k < NUM_PT; k++) begin : g_term_cfg
    always_ff @(posedge clk) begin
      if (cfg_we && cfg_addr == CFG_AW'(k)) term_cfg[k] <= cfg_data;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out_cfg
    always_ff @(posedge clk) begin
      if (cfg_we && cfg_addr == CFG_AW'(NUM_PT + i))
        out_cfg[i] <= out_cfg_t'(cfg_data[OCW-1:0]);
    end
  end

  ptsb_and_array #(.NUM_IN(NUM_IN), .NUM_PT(NUM_PT)) u_and (
    .in_vec  (in_vec),
    .lit_cfg (term_cfg),
    .pt      (pt)
  );

  ptsb_share_array #(.NUM_PT(NUM_PT)) u_share (
    .pt  (pt),
    .grp (grp)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
    ptsb_out_cell #(.NUM_CE(NUM_CE)) u_cell (
      .clk (clk),
      .rst (rst),
      .ce  (clk_en),
      .grp (grp),
      .cfg (out_cfg[i]),
      .y   (y_out[i])
    );
  end

endmodule

// File: tb/pt_share_block_bench.sv
module pt_share_block_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] in_route = '0;
  logic [1:0]  in_ded = '0;
  logic [2:0]  clk_en = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [35:0] cfg_data = '0;
  logic [3:0]  y_out;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pt_share_block u_pt_share_block (
    .clk(clk), .rst(rst), .in_route(in_route), .in_ded(in_ded),
    .clk_en(clk_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .y_out(y_out)
  );

  // {in_route, in_ded, expected y_out} with every output bypassed
  // gate0 = in0 | (in1 & ~in2), gate1 = ded0, gate2 = in3 & in4, gate3 = ~ded1 | in5
  // y0 = gate0, y1 = gate1, y2 = gate2 ^ gate3, y3 = gate0
  localparam logic [21:0] VECS [8] = '{
    {16'h0000, 2'b00, 4'b0100},
    {16'h0001, 2'b10, 4'b1001},
    {16'h0002, 2'b01, 4'b1111},
    {16'h0006, 2'b11, 4'b0010},
    {16'h0018, 2'b10, 4'b0100},
    {16'h0038, 2'b10, 4'b0000},
    {16'h0029, 2'b00, 4'b1101},
    {16'hFFC0, 2'b10, 4'b0000}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [35:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input logic [15:0] r, input logic [1:0] d, input logic [2:0] ce,
                      input string req, input logic [3:0] exp);
    @(negedge clk);
    in_route = r; in_ded = d; clk_en = ce;
    @(posedge clk);
    #1;
    check(req, y_out, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3: term programming; unlisted terms left empty
    for (int k = 0; k < 20; k++) cfg_write(5'(k), 36'h0);
    cfg_write(5'd0,  36'h0_0000_0001);
    cfg_write(5'd1,  36'h0_0000_0024);
    cfg_write(5'd4,  36'h1_0000_0000);
    cfg_write(5'd8,  36'h0_0000_0140);
    cfg_write(5'd13, 36'h8_0000_0000);
    cfg_write(5'd14, 36'h0_0000_0400);
    // R4 R9: all outputs bypassed, outputs 0 and 3 share gate 0
    cfg_write(5'd20, 36'h040);
    cfg_write(5'd21, 36'h041);
    cfg_write(5'd22, 36'h07E);
    cfg_write(5'd23, 36'h040);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      in_route = VECS[v][21:6];
      in_ded   = VECS[v][5:4];
      #2;
      check("R1 R2 R3 R4 R9 table", y_out, VECS[v][3:0]);
    end

    // Registered setup: D on ce0, T on ce1, JK on ce2, XOR on never-enable
    cfg_write(5'd20, 36'h000);
    cfg_write(5'd21, 36'h091);
    cfg_write(5'd22, 36'h124);
    cfg_write(5'd23, 36'h1BE);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 reset state", y_out, 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    step(16'h0001, 2'b00, 3'b111, "R5 R6 R7 set", 4'b0101);
    step(16'h0000, 2'b01, 3'b111, "R5 R6 R7 clear", 4'b0010);
    step(16'h0001, 2'b01, 3'b111, "R6 R7 toggle", 4'b0101);
    step(16'h0001, 2'b01, 3'b000, "R10 hold", 4'b0101);
    step(16'h0001, 2'b01, 3'b010, "R10 single enable", 4'b0111);
    step(16'h0000, 2'b00, 3'b100, "R7 hold", 4'b0111);
    step(16'h0000, 2'b00, 3'b001, "R5 load zero", 4'b0110);

    // R12: unused address must not disturb anything
    cfg_write(5'd25, {36{1'b1}});
    #1;
    check("R12 unused address", y_out, 4'b0110);

    // R8: output 3 moved to enable 0, XOR of gate2 and gate3
    cfg_write(5'd23, 36'h03E);
    step(16'h0018, 2'b10, 3'b001, "R8 xor load", 4'b1110);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 reset clears", y_out, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    step(16'h0001, 2'b00, 3'b111, "R11 config kept", 4'b1101);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule